// File: doc/BRIEF.md
# Tamper Edge Latch with Event Time Capture

This block watches an external tamper line and remembers that a tamper event happened. The first rising edge on the line after the flag was last cleared sets a sticky flag. From then on the line is ignored, whatever it does, until host software clears the flag. The flag is visible to the host as the top bit of control register 0. Edge capture keeps working while the main supply is down and the clock runs from the backup source. Host reads and writes are honoured only while main power is reported good.

When the capture-enable bit (bit 6 of register 1) is set, the same edge copies the running time into the user-visible time holding registers. The host can then read back when the event occurred. Those holding registers are shared with the host's ordinary snapshot request, so a later snapshot overwrites a stored event time. Software should therefore check the flag before requesting a snapshot. If both loads arrive in the same cycle, the event capture takes the slot and the snapshot is dropped.

Top module: `tamper_stamp`

## Requirements
- R1: A synchronous reset (power-up without backup) clears the tamper flag, the capture-enable bit, all holding registers, both load pulses and the read data to zero.
- R2: A rising edge on `tamper_i` sets `tamper_flag_o`. The flag appears SYNC_STAGES+1 clock edges after the first edge that samples the input high (3 with defaults). Before reset release, the input counts as low.
- R3: While the flag is set, every further transition on `tamper_i` is ignored: the flag stays at 1, no capture pulse occurs and the holding registers keep their value.
- R4: A host write to address 0 with data bit 7 equal to 0 clears the flag. A write with bit 7 equal to 1 never sets the flag.
- R5: While `main_pwr_ok_i` is low, host writes have no effect and `host_rdata_o` reads 0. Tamper edges are still captured in that state.
- R6: A host write to address 1 loads data bit 6 into the capture-enable bit. The bit reads back at bit 6 of address 1.
- R7: When capture-enable is 1, the edge that sets the flag loads `cur_time_i` into the holding registers and pulses `stamp_load_o` for one cycle. When capture-enable is 0, no time is loaded.
- R8: A one-cycle `cap_req_i` loads `cur_time_i` into the holding registers and pulses `cap_load_o` on the following edge. This overwrites any stored event time. The holding registers change only with one of the two pulses.
- R9: If an event capture and `cap_req_i` fall on the same edge, `stamp_load_o` pulses, `cap_load_o` stays low and the snapshot request is discarded.
- R10: An edge that would fire in the same cycle as a flag-clearing write is ignored. After a clear, the line must go low and rise again to set the flag, so a line held high does not retrigger.
- R11: Read data is registered one cycle after the address. Address 0 returns the flag at bit 7. Address 1 returns capture-enable at bit 6. Address 2+i returns holding byte i, where byte i is `hold_time_o[8i+7:8i]`. All other addresses and bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, power-up without backup |
| tamper_i | input | 1 | External tamper line, asynchronous |
| main_pwr_ok_i | input | 1 | Main supply good; gates host access |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | 8 | Host write data |
| cap_req_i | input | 1 | Host snapshot request pulse |
| cur_time_i | input | TIME_W | Running time from the timekeeper core |
| tamper_flag_o | output | 1 | Sticky tamper flag |
| stamp_load_o | output | 1 | Pulse: holding registers loaded by a tamper event |
| cap_load_o | output | 1 | Pulse: holding registers loaded by a snapshot |
| hold_time_o | output | TIME_W | Holding registers (user-visible time image) |
| host_rdata_o | output | 8 | Registered host read data |

## Verification
The bench targets these corner cases:
- **Edges while the flag is set.** A line that bounces low and high while the flag is up must not cause a second capture. A design that re-arms on the falling edge would overwrite the event time.
- **Clear racing an edge, and a line held high.** A clear that lands in the same cycle as a new edge, and a clear issued while the line stays high, must both leave the flag at 0. A level-sensitive latch would immediately set the flag again.
- **Capture colliding with a snapshot.** When an event capture and a snapshot request meet on the same edge, a design with the wrong priority would pulse the snapshot load instead of the event load.
- **Access with main power down.** With main power down, a clear must be refused while an edge is still latched. A design that gates the whole block on power would miss the event.

// File: rtl/tamper_pkg.sv
`timescale 1ns/1ps
package tamper_pkg;
  localparam int BYTE_W         = 8;
  // register indices decoded by the host side
  localparam int CTRL_ADDR      = 0;
  localparam int CFG_ADDR       = 1;
  localparam int TIME_BASE_ADDR = 2;
  // bit positions inside the host-visible bytes
  localparam int FLAG_BIT       = 7;
  localparam int TSEN_BIT       = 6;

  typedef enum logic [1:0] {
    LOAD_NONE    = 2'd0,
    LOAD_EVENT   = 2'd1,
    LOAD_CAPTURE = 2'd2
  } load_src_e;
endpackage

// File: rtl/tamper_sync.sv
`timescale 1ns/1ps
module tamper_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_flag_ctl.sv
`timescale 1ns/1ps
module tamper_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic clr_i,
  output logic fire_o,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic rise;

  // previous sample of the synchronised line; reset models a low line
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  assign rise   = sync_i & ~prev_q;
  // only an armed latch (flag clear) accepts an edge
  assign fire_o = rise & ~flag_q;

  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (fire_o) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/stamp_bank.sv
`timescale 1ns/1ps
module stamp_bank
  import tamper_pkg::*;
#(
  parameter int TIME_BYTES = 7,
  localparam int TIME_W    = TIME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_req_i,
  input  logic              cap_req_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] hold_o,
  output logic              event_load_o,
  output logic              cap_load_o
);
  load_src_e src;
  logic      load_en;

  // event capture outranks the host snapshot
  always_comb begin
    if (event_req_i)    src = LOAD_EVENT;
    else if (cap_req_i) src = LOAD_CAPTURE;
    else                src = LOAD_NONE;
  end

  assign load_en = (src != LOAD_NONE);

  genvar b;
  generate
    for (b = 0; b < TIME_BYTES; b++) begin : g_byte
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst)          byte_q <= '0;
        else if (load_en) byte_q <= time_i[b*BYTE_W +: BYTE_W];
      end
      assign hold_o[b*BYTE_W +: BYTE_W] = byte_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      event_load_o <= 1'b0;
      cap_load_o   <= 1'b0;
    end else begin
      event_load_o <= (src == LOAD_EVENT);
      cap_load_o   <= (src == LOAD_CAPTURE);
    end
  end
endmodule

// File: rtl/tamper_host_regs.sv
`timescale 1ns/1ps
module tamper_host_regs
  import tamper_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int TIME_BYTES = 7,
  localparam int TIME_W    = TIME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              flag_i,
  input  logic [TIME_W-1:0] hold_i,
  output logic              clr_o,
  output logic              tsen_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic              access;
  logic              tsen_q;
  logic [BYTE_W-1:0] rdata_d;
  logic [BYTE_W-1:0] rdata_q;
  wire               unused_wdata_bits = ^wdata_i[TSEN_BIT-1:0];

  assign access = wr_i & pwr_ok_i;
  // writing a 0 into the flag position is the only way to clear it
  assign clr_o  = access && (addr_i == ADDR_W'(CTRL_ADDR)) && !wdata_i[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      tsen_q <= 1'b0;
    else if (access && (addr_i == ADDR_W'(CFG_ADDR)))
      tsen_q <= wdata_i[TSEN_BIT];
  end

  always_comb begin
    rdata_d = '0;
    if (pwr_ok_i) begin
      if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_d[FLAG_BIT] = flag_i;
      if (addr_i == ADDR_W'(CFG_ADDR))  rdata_d[TSEN_BIT] = tsen_q;
      for (int i = 0; i < TIME_BYTES; i++) begin
        if (addr_i == ADDR_W'(TIME_BASE_ADDR + i))
          rdata_d = hold_i[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign tsen_o  = tsen_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/tamper_stamp.sv
`timescale 1ns/1ps
module tamper_stamp
  import tamper_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int TIME_BYTES  = 7,
  localparam int TIME_W     = TIME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tamper_i,
  input  logic              main_pwr_ok_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              cap_req_i,
  input  logic [TIME_W-1:0] cur_time_i,
  output logic              tamper_flag_o,
  output logic              stamp_load_o,
  output logic              cap_load_o,
  output logic [TIME_W-1:0] hold_time_o,
  output logic [7:0]        host_rdata_o
);
  logic tamper_sync_s;
  logic fire;
  logic clr;
  logic tsen_q;
  logic flag;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(tamper_i),
    .sync_o (tamper_sync_s)
  );

  tamper_flag_ctl u_flag (
    .clk   (clk),
    .rst   (rst),
    .sync_i(tamper_sync_s),
    .clr_i (clr),
    .fire_o(fire),
    .flag_o(flag)
  );

  tamper_host_regs #(.ADDR_W(ADDR_W), .TIME_BYTES(TIME_BYTES)) u_host (
    .clk     (clk),
    .rst     (rst),
    .pwr_ok_i(main_pwr_ok_i),
    .wr_i    (host_wr_i),
    .addr_i  (host_addr_i),
    .wdata_i (host_wdata_i),
    .flag_i  (flag),
    .hold_i  (hold_time_o),
    .clr_o   (clr),
    .tsen_o  (tsen_q),
    .rdata_o (host_rdata_o)
  );

  stamp_bank #(.TIME_BYTES(TIME_BYTES)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .event_req_i (fire & tsen_q),
    .cap_req_i   (cap_req_i),
    .time_i      (cur_time_i),
    .hold_o      (hold_time_o),
    .event_load_o(stamp_load_o),
    .cap_load_o  (cap_load_o)
  );

  assign tamper_flag_o = flag;
endmodule

// File: rtl/tamper_stamp_chk.sv
`timescale 1ns/1ps
module tamper_stamp_chk #(
  parameter int ADDR_W = 4,
  parameter int TIME_W = 56
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_ok,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              wdata_flag,
  input logic              tsen,
  input logic              flag,
  input logic              stamp,
  input logic              cap,
  input logic [TIME_W-1:0] hold,
  input logic [7:0]        rdata
);
  logic clr_cond;
  assign clr_cond = wr && pwr_ok && (addr == '0) && !wdata_flag;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!flag && !stamp && !cap && hold == '0 && rdata == 8'h00)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_cond) |=> flag); // R3

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag && clr_cond) |=> !flag); // R4

  AST_NO_READ_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (rdata == 8'h00)); // R5

  AST_STAMP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    stamp |-> ($past(tsen) && flag)); // R7

  AST_STAMP_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    stamp |=> !stamp); // R3

  AST_HOLD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!stamp && !cap) |-> $stable(hold)); // R8

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(stamp && cap)); // R9
endmodule

bind tamper_stamp tamper_stamp_chk #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_ok    (main_pwr_ok_i),
  .wr        (host_wr_i),
  .addr      (host_addr_i),
  .wdata_flag(host_wdata_i[7]),
  .tsen      (tsen_q),
  .flag      (tamper_flag_o),
  .stamp     (stamp_load_o),
  .cap       (cap_load_o),
  .hold      (hold_time_o),
  .rdata     (host_rdata_o)
);

// File: tb/tamper_stamp_bench.sv
`timescale 1ns/1ps
module tamper_stamp_bench;
  localparam int SYNC   = 2;
  localparam int ADDR_W = 4;
  localparam int NBYTES = 7;
  localparam int TW     = NBYTES * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tin = 1'b0;
  logic          pwr = 1'b1;
  logic          wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          capreq = 1'b0;
  logic [TW-1:0] cur = '0;
  logic          flag_o, stamp_o, cap_o;
  logic [TW-1:0] hold_o;
  logic [7:0]    rdata_o;

  int vectors = 0;
  int fails   = 0;
  int n_stamp = 0;
  int n_cap   = 0;
  bit cmp_en  = 0;
  bit done    = 0;

  always #4 clk = ~clk; // 125 MHz

  tamper_stamp #(.SYNC_STAGES(SYNC), .ADDR_W(ADDR_W), .TIME_BYTES(NBYTES)) u_tamper_stamp (
    .clk(clk), .rst(rst), .tamper_i(tin), .main_pwr_ok_i(pwr),
    .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wdata),
    .cap_req_i(capreq), .cur_time_i(cur),
    .tamper_flag_o(flag_o), .stamp_load_o(stamp_o), .cap_load_o(cap_o),
    .hold_time_o(hold_o), .host_rdata_o(rdata_o)
  );

  // ---------------- behavioural reference ----------------
  bit            hist[$];
  bit            m_flag, m_tsen, m_stamp, m_cap;
  logic [TW-1:0] m_hold;
  logic [7:0]    m_rdata;

  always @(posedge clk) begin
    bit ev, fire, clr, st, cp;
    logic [7:0] rd;
    if (rst) begin
      m_flag = 0; m_tsen = 0; m_stamp = 0; m_cap = 0; m_hold = '0; m_rdata = '0;
      hist.delete();
      for (int k = 0; k < SYNC + 2; k++) hist.push_front(1'b0);
      cmp_en = 1;
    end else begin
      hist.push_front(tin);
      while (hist.size() > SYNC + 2) void'(hist.pop_back());
      ev   = hist[SYNC] && !hist[SYNC+1];
      fire = ev && !m_flag;
      clr  = wr && pwr && addr == 0 && !wdata[7];
      rd = 8'h00;
      if (pwr) begin
        if (addr == 0) rd = {m_flag, 7'b0};
        else if (addr == 1) rd = {1'b0, m_tsen, 6'b0};
        else if (addr >= 2 && addr < 2 + NBYTES) rd = m_hold[(int'(addr) - 2) * 8 +: 8];
      end
      st = fire && m_tsen;
      cp = capreq && !st;
      if (st || cp) m_hold = cur;
      if (fire) m_flag = 1;
      else if (clr) m_flag = 0;
      if (wr && pwr && addr == 1) m_tsen = wdata[6];
      m_stamp = st; m_cap = cp; m_rdata = rd;
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      vectors++;
      if (flag_o !== m_flag) begin fails++; $display("FAIL R2 flag: got %0b exp %0b", flag_o, m_flag); end
      if (stamp_o !== m_stamp) begin fails++; $display("FAIL R7 stamp pulse: got %0b exp %0b", stamp_o, m_stamp); end
      if (cap_o !== m_cap) begin fails++; $display("FAIL R9 capture pulse: got %0b exp %0b", cap_o, m_cap); end
      if (hold_o !== m_hold) begin fails++; $display("FAIL R8 hold: got %h exp %h", hold_o, m_hold); end
      if (rdata_o !== m_rdata) begin fails++; $display("FAIL R11 rdata: got %h exp %h", rdata_o, m_rdata); end
      if (stamp_o === 1'b1) n_stamp++;
      if (cap_o === 1'b1) n_cap++;
    end
  end

  // ---------------- directed checks ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 8'h00;
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata_o;
  endtask

  localparam logic [TW-1:0] T0 = 56'h24_11_25_03_17_42_09;
  localparam logic [TW-1:0] T1 = 56'h25_06_30_01_23_59_58;
  localparam logic [TW-1:0] T2 = 56'h25_07_01_02_00_00_07;
  localparam logic [TW-1:0] T3 = 56'h99_12_31_07_11_11_11;

  initial begin
    logic [7:0] rd;
    cycles(5);
    @(negedge clk) rst = 0;
    cycles(1);
    // R1 reset state
    check("R1 flag", {63'b0, flag_o}, 64'd0);
    check("R1 hold", {8'b0, hold_o}, 64'd0);
    check("R1 rdata", {56'b0, rdata_o}, 64'd0);

    // R2 edge sets flag; R7 no time loaded with enable clear
    cur = T0;
    @(negedge clk) tin = 1;
    cycles(5);
    check("R2 flag set by edge", {63'b0, flag_o}, 64'd1);
    check("R7 no stamp when disabled", {8'b0, hold_o}, 64'd0);

    // R3 bouncing line ignored
    n_stamp = 0;
    @(negedge clk) tin = 0; cycles(2);
    tin = 1; cycles(2);
    tin = 0; cycles(5);
    check("R3 flag stays", {63'b0, flag_o}, 64'd1);
    check("R3 no capture", 64'(n_stamp), 64'd0);

    // R5 writes and reads refused with main power down
    pwr = 0;
    host_write(0, 8'h00);
    cycles(2);
    check("R5 clear refused", {63'b0, flag_o}, 64'd1);
    host_read(0, rd);
    check("R5 read zero", {56'b0, rd}, 64'd0);

    // R4 clear; R10 held-high line does not retrigger
    pwr = 1;
    @(negedge clk) tin = 1;
    cycles(5);
    host_write(0, 8'h00);
    cycles(6);
    check("R4 flag cleared", {63'b0, flag_o}, 64'd0);
    check("R10 no retrigger while high", {63'b0, flag_o}, 64'd0);
    host_write(0, 8'h80);
    cycles(2);
    check("R4 write of 1 does not set", {63'b0, flag_o}, 64'd0);

    // R6 enable bit
    host_write(1, 8'h40);
    host_read(1, rd);
    check("R6 enable readback", {56'b0, rd}, 64'h40);

    // R7 event time capture
    @(negedge clk) tin = 0;
    cycles(4);
    cur = T1; n_stamp = 0;
    tin = 1;
    cycles(6);
    check("R7 flag", {63'b0, flag_o}, 64'd1);
    check("R7 stamped time", {8'b0, hold_o}, {8'b0, T1});
    check("R7 one pulse", 64'(n_stamp), 64'd1);
    host_read(0, rd);
    check("R11 flag at bit 7", {56'b0, rd}, 64'h80);
    host_read(2, rd);
    check("R11 byte 0", {56'b0, rd}, {56'b0, T1[7:0]});
    host_read(8, rd);
    check("R11 byte 6", {56'b0, rd}, {56'b0, T1[55:48]});
    host_read(9, rd);
    check("R11 unmapped", {56'b0, rd}, 64'd0);

    // R8 snapshot overwrites stamp
    cur = T2; n_cap = 0;
    @(negedge clk) capreq = 1;
    @(negedge clk) capreq = 0;
    cycles(1);
    check("R8 snapshot time", {8'b0, hold_o}, {8'b0, T2});
    check("R8 one pulse", 64'(n_cap), 64'd1);

    // R9 collision: event beats snapshot
    host_write(0, 8'h00);
    @(negedge clk) tin = 0;
    cycles(4);
    n_stamp = 0; n_cap = 0; cur = T3;
    @(negedge clk) tin = 1;
    @(negedge clk);
    @(negedge clk) capreq = 1;
    @(negedge clk) capreq = 0;
    cycles(3);
    check("R9 event pulse", 64'(n_stamp), 64'd1);
    check("R9 snapshot dropped", 64'(n_cap), 64'd0);
    check("R9 hold", {8'b0, hold_o}, {8'b0, T3});

    // R10 clear in the same cycle as a new edge
    @(negedge clk) tin = 0;
    cycles(4);
    n_stamp = 0;
    @(negedge clk) tin = 1;
    @(negedge clk);
    @(negedge clk) begin wr = 1; addr = 0; wdata = 8'h00; end
    @(negedge clk) wr = 0;
    cycles(6);
    check("R10 racing edge ignored", {63'b0, flag_o}, 64'd0);
    check("R10 no capture", 64'(n_stamp), 64'd0);

    // R5 edge captured on backup power
    pwr = 0;
    @(negedge clk) tin = 0;
    cycles(4);
    cur = T0; n_stamp = 0;
    tin = 1;
    cycles(6);
    check("R5 edge on backup", {63'b0, flag_o}, 64'd1);
    check("R5 stamp on backup", {8'b0, hold_o}, {8'b0, T0});
    check("R5 rdata gated", {56'b0, rdata_o}, 64'd0);

    cycles(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule